// File: doc/BRIEF.md
# Interrupt and Alert Register Block

This block gathers a peripheral's interrupt and alert event sources behind a plain word-addressed register port. Four registers sit at consecutive word indices starting at a parameterised base. The interrupt state register latches hardware events and is cleared by software writing ones. The interrupt enable register is a plain read/write mask. The interrupt test register lets software force state bits high. The alert test register lets software fire single alert events. Each interrupt source and each alert source occupies one bit, packed upward from bit 0 in source order.

The interrupt outputs are level signals: each is high while its state bit and its enable bit are both set. The alert outputs are event lines. Each one carries the hardware alert request for its bit, merged with a one-cycle test pulse that is produced when software writes a 1 to that bit of the alert test register. Neither test register holds a value. A write to either one acts only in the cycle of the write, and both read back as zero.

Top module: `intr_alert_csr`

## Requirements
- R1: After reset, every register field is zero. All reads return 0, `intr_o` is 0, and `alert_o` equals `hw_alert_req`.
- R2: The register at word index BASE_IDX holds the interrupt state. A 1 on `hw_intr_evt[i]` at a clock edge sets state bit i, and the bit reads back as 1 at that index.
- R3: A write to the state index clears each state bit whose `bus_wdata` bit is 1. State bits whose `bus_wdata` bit is 0 keep their value.
- R4: A hardware event and a software clear of the same state bit at the same edge leave that bit set.
- R5: Word index BASE_IDX+1 is the interrupt enable register. It is read/write, and it changes only when written. Bits at or above NUM_INTR read as 0.
- R6: `intr_o[i]` is high exactly when state bit i and enable bit i are both 1.
- R7: Word index BASE_IDX+2 is the interrupt test register. Writing 1 to bit i sets state bit i at that edge. The register stores nothing and reads as 0.
- R8: Word index BASE_IDX+3 is the alert test register. Writing 1 to bit j raises `alert_o[j]` for exactly the one cycle after the write edge. The register reads as 0.
- R9: `alert_o[j]` is high in any cycle in which `hw_alert_req[j]` is high.
- R10: Writes to any other word index change no register and produce no alert pulse. Reads of any other word index return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word index of the access |
| bus_wdata | input | DW | Write data, bit i maps to source i |
| bus_rdata | output | DW | Read data, combinational during a read request |
| hw_intr_evt | input | NUM_INTR | Hardware interrupt events, one per source |
| hw_alert_req | input | NUM_ALERT | Hardware alert requests, one per source |
| intr_o | output | NUM_INTR | Enabled interrupt levels |
| alert_o | output | NUM_ALERT | Alert event lines |

## Verification
Read data and the hardware side of `alert_o` are combinational, so they are compared in the same cycle the access or request is applied. State, enable and `intr_o` reflect a write or an event from the first cycle after that clock edge. The alert test pulse is due in that same cycle and must be gone in the cycle after it. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. It advances its reference model only after the rising edge, so each comparison matches the register latency above.

// File: rtl/intr_alert_csr.sv
module intr_alert_csr #(
  parameter int DW        = 32,
  parameter int AW        = 4,
  parameter int NUM_INTR  = 8,
  parameter int NUM_ALERT = 4,
  parameter int BASE_IDX  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NUM_INTR-1:0]  hw_intr_evt,
  input  logic [NUM_ALERT-1:0] hw_alert_req,
  output logic [NUM_INTR-1:0]  intr_o,
  output logic [NUM_ALERT-1:0] alert_o
);

  localparam logic [AW-1:0] A_STATE = AW'(BASE_IDX);
  localparam logic [AW-1:0] A_EN    = AW'(BASE_IDX + 1);
  localparam logic [AW-1:0] A_ITEST = AW'(BASE_IDX + 2);
  localparam logic [AW-1:0] A_ATEST = AW'(BASE_IDX + 3);

  if (NUM_INTR > DW || NUM_ALERT > DW || NUM_INTR < 1 || NUM_ALERT < 1) begin : g_bad_cfg
    $error("source counts must lie between 1 and the register width");
  end

  logic [NUM_INTR-1:0]  intr_state_q;
  logic [NUM_INTR-1:0]  intr_en_q;
  logic [NUM_ALERT-1:0] alert_pulse_q;

  logic wr, wr_state, wr_en, itest_qe, atest_qe;
  assign wr       = bus_req & bus_wr;
  assign wr_state = wr && (bus_addr == A_STATE);
  assign wr_en    = wr && (bus_addr == A_EN);
  assign itest_qe = wr && (bus_addr == A_ITEST);
  assign atest_qe = wr && (bus_addr == A_ATEST);

  logic [NUM_INTR-1:0]  wd_intr;
  logic [NUM_ALERT-1:0] wd_alert;
  assign wd_intr  = bus_wdata[NUM_INTR-1:0];
  assign wd_alert = bus_wdata[NUM_ALERT-1:0];

  logic [NUM_INTR-1:0] sw_clr, intr_set;
  assign sw_clr   = wr_state ? wd_intr : '0;
  assign intr_set = hw_intr_evt | (itest_qe ? wd_intr : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_state_q  <= '0;
      intr_en_q     <= '0;
      alert_pulse_q <= '0;
    end else begin
      intr_state_q  <= (intr_state_q & ~sw_clr) | intr_set;
      if (wr_en) intr_en_q <= wd_intr;
      alert_pulse_q <= atest_qe ? wd_alert : '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_wr) begin
      if (bus_addr == A_STATE)   bus_rdata = DW'(intr_state_q);
      else if (bus_addr == A_EN) bus_rdata = DW'(intr_en_q);
    end
  end

  assign intr_o  = intr_state_q & intr_en_q;
  assign alert_o = hw_alert_req | alert_pulse_q;

endmodule

// File: rtl/intr_alert_csr_chk.sv
module intr_alert_csr_chk #(
  parameter int DW        = 32,
  parameter int AW        = 4,
  parameter int NUM_INTR  = 8,
  parameter int NUM_ALERT = 4,
  parameter int BASE_IDX  = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 bus_wr,
  input logic [AW-1:0]        bus_addr,
  input logic [DW-1:0]        bus_wdata,
  input logic [DW-1:0]        bus_rdata,
  input logic [NUM_INTR-1:0]  hw_intr_evt,
  input logic [NUM_ALERT-1:0] hw_alert_req,
  input logic [NUM_INTR-1:0]  intr_o,
  input logic [NUM_ALERT-1:0] alert_o,
  input logic [NUM_INTR-1:0]  st,
  input logic [NUM_INTR-1:0]  en
);
  localparam logic [AW-1:0] A_S  = AW'(BASE_IDX);
  localparam logic [AW-1:0] A_E  = AW'(BASE_IDX + 1);
  localparam logic [AW-1:0] A_IT = AW'(BASE_IDX + 2);
  localparam logic [AW-1:0] A_AT = AW'(BASE_IDX + 3);

  logic wr, rd, mapped;
  logic [NUM_INTR-1:0]  wdi;
  logic [NUM_ALERT-1:0] wda;
  assign wr     = bus_req && bus_wr;
  assign rd     = bus_req && !bus_wr;
  assign mapped = (bus_addr == A_S) || (bus_addr == A_E) || (bus_addr == A_IT) || (bus_addr == A_AT);
  assign wdi    = bus_wdata[NUM_INTR-1:0];
  assign wda    = bus_wdata[NUM_ALERT-1:0];

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_intr_evt != '0) |=> ((st & $past(hw_intr_evt)) == $past(hw_intr_evt)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_S && (wdi & ~hw_intr_evt) != '0) |=> ((st & $past(wdi & ~hw_intr_evt)) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_S && (wdi & hw_intr_evt) != '0) |=> ((st & $past(wdi & hw_intr_evt)) == $past(wdi & hw_intr_evt)));

  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_E) |=> $stable(en));

  p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((intr_o & ~en) == '0) && ((intr_o & ~st) == '0));

  p_itest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_IT) |=> ((st & $past(wdi)) == $past(wdi)));

  p_test_rd0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (bus_addr == A_IT || bus_addr == A_AT)) |-> (bus_rdata == '0));

  p_atest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_AT) |=> ((alert_o & $past(wda)) == $past(wda)));

  p_alert_hw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((alert_o & hw_alert_req) == hw_alert_req));

  p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mapped) |-> (bus_rdata == '0));

  p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !mapped && hw_intr_evt == '0) |=> ($stable(st) && $stable(en)));
endmodule

bind intr_alert_csr intr_alert_csr_chk #(
  .DW(DW), .AW(AW), .NUM_INTR(NUM_INTR), .NUM_ALERT(NUM_ALERT), .BASE_IDX(BASE_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_intr_evt(hw_intr_evt),
  .hw_alert_req(hw_alert_req), .intr_o(intr_o), .alert_o(alert_o),
  .st(intr_state_q), .en(intr_en_q)
);

// File: tb/sim_intr_alert_csr.sv
module sim_intr_alert_csr;
  localparam int DW = 32, AW = 4, NI = 8, NA = 4, BASE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NI-1:0] hw_intr_evt = '0;
  logic [NA-1:0] hw_alert_req = '0;
  logic [NI-1:0] intr_o;
  logic [NA-1:0] alert_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [NI-1:0] m_st = '0, m_en = '0;
  logic [NA-1:0] m_pulse = '0;

  always #2 clk = ~clk;

  intr_alert_csr #(.DW(DW), .AW(AW), .NUM_INTR(NI), .NUM_ALERT(NA), .BASE_IDX(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_intr_evt(hw_intr_evt),
    .hw_alert_req(hw_alert_req), .intr_o(intr_o), .alert_o(alert_o));

  function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
    if (a == AW'(BASE))     return DW'(m_st);
    if (a == AW'(BASE + 1)) return DW'(m_en);
    return '0;
  endfunction

  function automatic string tag_of(logic [AW-1:0] a);
    if (a == AW'(BASE))     return "R2";
    if (a == AW'(BASE + 1)) return "R5";
    if (a == AW'(BASE + 2)) return "R7";
    if (a == AW'(BASE + 3)) return "R8";
    return "R10";
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit rq, bit wr, logic [AW-1:0] a, logic [DW-1:0] wd,
                      logic [NI-1:0] ev, logic [NA-1:0] ar, string rtag);
    logic [NI-1:0] clr, tst;
    @(negedge clk);
    bus_req = rq; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    hw_intr_evt = ev; hw_alert_req = ar;
    #1;
    check("R6", DW'(intr_o), DW'(m_st & m_en));
    check((m_pulse != '0) ? "R8" : "R9", DW'(alert_o), DW'(ar | m_pulse));
    if (rq && !wr) check(rtag, bus_rdata, exp_rd(a));
    @(posedge clk);
    clr = (rq && wr && a == AW'(BASE)) ? wd[NI-1:0] : '0;
    tst = (rq && wr && a == AW'(BASE + 2)) ? wd[NI-1:0] : '0;
    m_st = (m_st & ~clr) | ev | tst;
    if (rq && wr && a == AW'(BASE + 1)) m_en = wd[NI-1:0];
    m_pulse = (rq && wr && a == AW'(BASE + 3)) ? wd[NA-1:0] : '0;
  endtask

  task automatic rd(logic [AW-1:0] a, string t);
    step(1, 0, a, '0, '0, '0, t);
  endtask

  task automatic wrt(logic [AW-1:0] a, logic [DW-1:0] d, logic [NI-1:0] ev);
    step(1, 1, a, d, ev, '0, "");
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at every mapped index
    for (int k = 0; k < 4; k++) rd(AW'(BASE + k), "R1");
    check("R1", DW'(intr_o), '0);
    // R2: hardware event sets state
    step(0, 0, '0, '0, 8'h08, '0, "");
    rd(AW'(BASE), "R2");
    // R3: write-one clears, zeros keep
    wrt(AW'(BASE), 32'h0, '0);
    rd(AW'(BASE), "R3");
    wrt(AW'(BASE), 32'h08, '0);
    rd(AW'(BASE), "R3");
    // R5: enable read/write, upper bits read zero
    wrt(AW'(BASE + 1), 32'hFFFF_FF0F, '0);
    rd(AW'(BASE + 1), "R5");
    // R4: set wins over clear
    wrt(AW'(BASE), 32'h02, 8'h02);
    rd(AW'(BASE), "R4");
    step(0, 0, '0, '0, '0, '0, "");
    check("R6", DW'(intr_o), 32'h02);
    // R7: interrupt test forces state, reads zero
    wrt(AW'(BASE + 2), 32'h80, '0);
    rd(AW'(BASE + 2), "R7");
    rd(AW'(BASE), "R7");
    // R8: alert test pulse for one cycle
    wrt(AW'(BASE + 3), 32'h5, '0);
    step(0, 0, '0, '0, '0, '0, "");
    step(0, 0, '0, '0, '0, '0, "");
    rd(AW'(BASE + 3), "R8");
    // R9: hardware alert passes through
    step(0, 0, '0, '0, '0, 4'hA, "");
    // R10: unmapped writes ignored, reads zero
    wrt(AW'(0), 32'hFF, '0);
    wrt(AW'(9), 32'hFF, '0);
    rd(AW'(0), "R10");
    rd(AW'(15), "R10");
    rd(AW'(BASE), "R10");
    rd(AW'(BASE + 1), "R10");
    step(0, 0, '0, '0, '0, '0, "");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % 16);
      step(($urandom % 4) != 0, $urandom % 2, a, $urandom,
           (($urandom % 4) == 0) ? NI'($urandom) : '0,
           (($urandom % 8) == 0) ? NA'($urandom) : '0, tag_of(a));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule